// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block turns a single host read request into the command sequence a synchronous DRAM with four banks and a 16-bit data bus needs for one burst read. The host gives a bank, a row and a column. The block drives the chip-select, row-strobe, column-strobe and write-enable command pins, the 13-bit address bus, the two bank-select lines, clock enable and the byte masks. It opens the row, waits the row-to-column delay, issues the read, and fills every later command slot with a no-operation. Once the CAS latency has passed it captures four consecutive words from the data bus.

The captured words come back to the host one per cycle with a valid strobe. A done pulse marks the fourth word. After the last word has left the bus the block closes the bank with a precharge and waits the row-precharge time before it takes the next request. Writes, refresh and device initialisation belong to other logic. Burst length and CAS latency are fixed parameters that must match the device's mode setting.

Top module: `sdram_burst_reader`

## Requirements
- R1: While reset is asserted the command pins carry NOP (csN,rasN,casN,weN = 0,1,1,1), rdValid and burstDone are low and reqReady is high.
- R2: A request with reqValid high in a cycle where reqReady is high is accepted. In the next cycle the pins carry ACTIVE (0,0,1,1), sdrAddr equals the requested row and sdrBa equals the requested bank.
- R3: READ (0,1,0,1) appears T_RCD cycles after ACTIVE, with NOP in between. sdrAddr bits 9:0 carry the column, bits 12:10 are zero (bit 10 low means no auto-precharge), and sdrBa is the accepted bank.
- R4: Every command cycle that carries neither ACTIVE, READ nor PRECHARGE is NOP with sdrAddr and sdrBa at zero. This includes every cycle of the burst after READ.
- R5: The word on sdrDq during cycle READ+CAS_LAT+i, for i = 0 to 3, appears on rdData with rdValid high in the following cycle. rdValid is high for exactly four consecutive cycles per burst.
- R6: burstDone is high for one cycle only, and that cycle is the one with the fourth rdValid.
- R7: PRECHARGE (0,0,1,0) appears in cycle READ+CAS_LAT+4, with sdrAddr bit 10 low (single bank) and sdrBa equal to the accepted bank.
- R8: reqReady stays low from the cycle after acceptance until T_RP cycles after PRECHARGE. reqValid and the request fields have no effect on the pins while reqReady is low.
- R9: sdrCke is high and both sdrDqm bits are low in every cycle after reset.
- R10: A request held high continuously is accepted again in the first cycle reqReady returns high. Each accepted request uses its own bank, row and column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the SDRAM |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host read request |
| reqBank | input | 2 | Requested bank |
| reqRow | input | 13 | Requested row |
| reqCol | input | 10 | Requested start column |
| reqReady | output | 1 | High when a request would be accepted |
| sdrCsN | output | 1 | Chip select, active low |
| sdrRasN | output | 1 | Row strobe, active low |
| sdrCasN | output | 1 | Column strobe, active low |
| sdrWeN | output | 1 | Write enable, active low |
| sdrAddr | output | 13 | Multiplexed row/column address |
| sdrBa | output | 2 | Bank select |
| sdrCke | output | 1 | Clock enable |
| sdrDqm | output | 2 | Byte data masks |
| sdrDq | input | 16 | Read data from the device |
| rdData | output | 16 | Captured burst word |
| rdValid | output | 1 | rdData holds a word |
| burstDone | output | 1 | Fourth word of the burst |

## Verification
The sequencer is driven with an isolated request at the column and row extremes, with a request held high without a break, and with sparse pseudo-random requests whose fields change every cycle. The isolated requests pin down the absolute spacing of ACTIVE, READ, the capture window and PRECHARGE. The held request shows that acceptance resumes in the first ready cycle with no idle gap. The fields that change while the block is busy show that nothing latches a request it should have ignored. The data bus carries a different value in every cycle, so a capture one cycle early or late shows up as a wrong word and not only as a misplaced strobe.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  // Command word ordered {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_ACT  = 4'b0011,
    CMD_READ = 4'b0101,
    CMD_PRE  = 4'b0010
  } sdrCmd_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic issueAct;
    logic issueRead;
    logic issuePre;
    logic capture;
    logic lastWord;
  } seqStrobe_t;

endpackage

// File: rtl/sdr_rd_ctrl.sv
module sdr_rd_ctrl
  import sdr_rd_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  localparam int STREAM_CYC = CAS_LAT + BURST_LEN;
  localparam int WAIT_MAX   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int CNT_MAX    = (WAIT_MAX > STREAM_CYC) ? WAIT_MAX : STREAM_CYC;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_OPEN, ST_STREAM, ST_CLOSE} seqState_e;

  seqState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.issueAct = 1'b1;
          stateNext       = ST_OPEN;
          cntNext         = CNT_W'(T_RCD - 1);
        end
      end
      ST_OPEN: begin
        if (cnt == '0) begin
          strobe.issueRead = 1'b1;
          stateNext        = ST_STREAM;
          cntNext          = CNT_W'(STREAM_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_STREAM: begin
        strobe.capture = (cnt < CNT_W'(BURST_LEN));
        if (cnt == '0) begin
          strobe.lastWord = 1'b1;
          strobe.issuePre = 1'b1;
          stateNext       = ST_CLOSE;
          cntNext         = CNT_W'(T_RP - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_CLOSE: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign reqReady = (state == ST_IDLE);

  // Only one command may be requested per slot (R4)
  assert_single_cmd_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.issueAct, strobe.issueRead, strobe.issuePre}));

  // The last word is always inside the capture window (R5)
  assert_last_in_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lastWord |-> strobe.capture);

  // Accepting a request makes the block busy next cycle (R8)
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/sdr_rd_dpath.sv
module sdr_rd_dpath
  import sdr_rd_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int BANK_W    = 2,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int AP_BIT    = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] sdrDq,
  output sdrCmd_e           cmd,
  output logic [ROW_W-1:0]  addr,
  output logic [BANK_W-1:0] ba,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              burstDone
);

  localparam int RUN_W = $clog2(BURST_LEN + 1);

  logic [BANK_W-1:0] bankQ;
  logic [COL_W-1:0]  colQ;
  logic [ROW_W-1:0]  colAddr;

  // Column placed in the low address bits, auto-precharge bit forced low
  always_comb begin
    colAddr                = '0;
    colAddr[COL_W-1:0]     = colQ;
    colAddr[AP_BIT]        = 1'b0;
  end

  // Request fields held from ACTIVE through PRECHARGE
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ <= '0;
      colQ  <= '0;
    end else if (strobe.issueAct) begin
      bankQ <= reqBank;
      colQ  <= reqCol;
    end
  end

  // Registered command, address and bank pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmd  <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
    end else if (strobe.issueAct) begin
      cmd  <= CMD_ACT;
      addr <= reqRow;
      ba   <= reqBank;
    end else if (strobe.issueRead) begin
      cmd  <= CMD_READ;
      addr <= colAddr;
      ba   <= bankQ;
    end else if (strobe.issuePre) begin
      cmd  <= CMD_PRE;
      addr <= '0;
      ba   <= bankQ;
    end else begin
      cmd  <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
    end
  end

  // Burst capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData    <= '0;
      rdValid   <= 1'b0;
      burstDone <= 1'b0;
    end else begin
      rdValid   <= strobe.capture;
      burstDone <= strobe.lastWord;
      if (strobe.capture) rdData <= sdrDq;
    end
  end

  // Length of the current run of valid words, for the checks below
  logic [RUN_W-1:0] validRun;
  always_ff @(posedge clk) begin
    if (!rstN)        validRun <= '0;
    else if (rdValid) validRun <= validRun + 1'b1;
    else              validRun <= '0;
  end

  assert_read_then_nop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_READ) |=> (cmd == CMD_NOP));

  assert_valid_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (validRun < RUN_W'(BURST_LEN)));

  assert_done_on_fourth_R6: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> (rdValid && validRun == RUN_W'(BURST_LEN - 1)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);

  assert_pre_with_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> (cmd == CMD_PRE && addr[AP_BIT] == 1'b0));

endmodule

// File: rtl/sdram_burst_reader.sv
module sdram_burst_reader
  import sdr_rd_pkg::*;
#(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int BANK_W    = 2,
  parameter int DATA_W    = 16,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int AP_BIT    = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [ROW_W-1:0]    reqRow,
  input  logic [COL_W-1:0]    reqCol,
  output logic                reqReady,
  output logic                sdrCsN,
  output logic                sdrRasN,
  output logic                sdrCasN,
  output logic                sdrWeN,
  output logic [ROW_W-1:0]    sdrAddr,
  output logic [BANK_W-1:0]   sdrBa,
  output logic                sdrCke,
  output logic [DATA_W/8-1:0] sdrDqm,
  input  logic [DATA_W-1:0]   sdrDq,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic                burstDone
);

  seqStrobe_t strobe;
  sdrCmd_e    cmd;

  sdr_rd_ctrl #(
    .T_RCD(T_RCD), .T_RP(T_RP), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .strobe(strobe)
  );

  sdr_rd_dpath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .BANK_W(BANK_W), .DATA_W(DATA_W),
    .BURST_LEN(BURST_LEN), .AP_BIT(AP_BIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .sdrDq(sdrDq),
    .cmd(cmd), .addr(sdrAddr), .ba(sdrBa),
    .rdData(rdData), .rdValid(rdValid), .burstDone(burstDone)
  );

  assign {sdrCsN, sdrRasN, sdrCasN, sdrWeN} = cmd;
  assign sdrCke = 1'b1;
  assign sdrDqm = '0;

  // An accepted request opens its row in the next cycle (R2)
  assert_accept_opens_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=>
      ({sdrCsN, sdrRasN, sdrCasN, sdrWeN} == 4'b0011 &&
       sdrAddr == $past(reqRow) && sdrBa == $past(reqBank)));

endmodule

// File: tb/sdram_burst_reader_bench.sv
module sdram_burst_reader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CL   = 2;
  localparam int TRCD = 2;
  localparam int TRP  = 2;
  localparam int NCYC = 340;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqBank;
  logic [12:0] reqRow;
  logic [9:0]  reqCol;
  logic        reqReady;
  logic        sdrCsN, sdrRasN, sdrCasN, sdrWeN;
  logic [12:0] sdrAddr;
  logic [1:0]  sdrBa;
  logic        sdrCke;
  logic [1:0]  sdrDqm;
  logic [15:0] sdrDq;
  logic [15:0] rdData;
  logic        rdValid;
  logic        burstDone;

  sdram_burst_reader u_sdram_burst_reader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .reqReady(reqReady),
    .sdrCsN(sdrCsN), .sdrRasN(sdrRasN), .sdrCasN(sdrCasN), .sdrWeN(sdrWeN),
    .sdrAddr(sdrAddr), .sdrBa(sdrBa), .sdrCke(sdrCke), .sdrDqm(sdrDqm),
    .sdrDq(sdrDq), .rdData(rdData), .rdValid(rdValid), .burstDone(burstDone)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dqOf(int n);
    return 16'((n * 32'h01F3) ^ 32'h5A3C);
  endfunction

  function automatic logic [31:0] mix(int n);
    logic [31:0] h;
    h = 32'(n) * 32'h9E3779B1;
    return h ^ (h >> 13);
  endfunction

  // Reference schedule of the most recent accepted request
  int actAt = -100, readAt = -100, preAt = -100, readyAt = 0;
  logic [1:0]  mBank;
  logic [12:0] mRow;
  logic [9:0]  mCol;

  initial begin
    logic [18:0] expPins, actPins;
    logic [31:0] h;
    bit          expValid;
    string       tag;
    rstN = 1'b0; reqValid = 1'b0; reqBank = '0; reqRow = '0; reqCol = '0;
    sdrDq = '0; mBank = '0; mRow = '0; mCol = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({sdrCsN, sdrRasN, sdrCasN, sdrWeN} == 4'b0111, "R1", "reset cmd",
          {28'd0, sdrCsN, sdrRasN, sdrCasN, sdrWeN}, 32'h7);
    check(!rdValid && !burstDone, "R1", "reset strobes", {30'd0, rdValid, burstDone}, 32'h0);
    check(reqReady, "R1", "reset ready", {31'd0, reqReady}, 32'h1);
    rstN = 1'b1;

    for (int n = 0; n < NCYC; n++) begin
      // ---- compare cycle n ----
      actPins = {sdrCsN, sdrRasN, sdrCasN, sdrWeN, sdrAddr, sdrBa};
      if (n == actAt) begin
        expPins = {4'b0011, mRow, mBank}; tag = "R2";
      end else if (n == readAt) begin
        expPins = {4'b0101, 3'b000, mCol, mBank}; tag = "R3";
      end else if (n == preAt) begin
        expPins = {4'b0010, 13'd0, mBank}; tag = "R7";
      end else begin
        expPins = {4'b0111, 13'd0, 2'd0}; tag = "R4";
      end
      check(actPins == expPins, tag, "command/addr/bank", {13'd0, actPins}, {13'd0, expPins});

      expValid = (n >= readAt + CL + 1) && (n <= readAt + CL + 4);
      check(rdValid == expValid, "R5", "rdValid", {31'd0, rdValid}, {31'd0, expValid});
      if (expValid && rdValid)
        check(rdData == dqOf(n - 1), "R5", "rdData", {16'd0, rdData}, {16'd0, dqOf(n - 1)});
      check(burstDone == (n == readAt + CL + 4), "R6", "burstDone",
            {31'd0, burstDone}, {31'd0, (n == readAt + CL + 4)});
      // R8 and, on the return cycle, R10
      check(reqReady == (n >= readyAt), (n == readyAt && n > 0) ? "R10" : "R8", "reqReady",
            {31'd0, reqReady}, {31'd0, (n >= readyAt)});
      check(sdrCke && sdrDqm == 2'b00, "R9", "cke/dqm", {29'd0, sdrCke, sdrDqm}, 32'h4);

      // ---- stimulus for cycle n ----
      sdrDq = dqOf(n);
      h = mix(n);
      reqBank = h[1:0]; reqRow = h[14:2]; reqCol = h[24:15];
      if (n == 2) begin
        reqValid = 1'b1; reqBank = 2'd1; reqRow = 13'h1ABC; reqCol = 10'h3FF;
      end else if (n == 30) begin
        reqValid = 1'b1; reqBank = 2'd3; reqRow = 13'h1FFF; reqCol = 10'h000;
      end else if (n >= 60 && n < 130) begin
        reqValid = 1'b1;              // R10: held request, fields change every cycle
      end else if (n >= 150 && n < 320) begin
        reqValid = h[27];
        h = mix(n + 7);
        reqBank = h[1:0]; reqRow = h[14:2]; reqCol = h[24:15];
      end else begin
        reqValid = 1'b0;
      end

      if (reqValid && n >= readyAt) begin
        actAt   = n + 1;
        readAt  = n + 1 + TRCD;
        preAt   = readAt + CL + 4;
        readyAt = preAt + TRP;
        mBank = reqBank; mRow = reqRow; mCol = reqCol;
      end
      @(negedge clk);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule